// File: doc/BRIEF.md
# Address-Space-Tagged Translation Buffer

This block caches virtual-to-physical page translations for a 32-bit address space. It has 128 entries arranged as 32 sets of 4 ways. Each entry carries an 8-bit address-space tag, a page-size bit (1 KB or 4 KB), a global flag, a physical page number and a 2-bit access-rights field. A lookup is purely combinational. In the same cycle it reports a hit, the translated physical address, the rights, the global flag, the matching way, a multiple-match error and an access-rights violation.

Software fills the buffer one entry per cycle through a write port. It can name the target way itself, or let a free-running 2-bit counter pick the way. A single-cycle invalidate input drops every entry at once. Page-table walking and exception sequencing belong to the surrounding logic.

Top module: `asid_tlb`

## Requirements
- R1: After reset, and with no write since, every lookup misses: `lk_hit`, `lk_multi` and `lk_viol` are 0, and `lk_pa` is 0.
- R2: A 4 KB entry (`wr_size`=1) hits when VA[31:12] equals its stored page-number bits [21:2] and the address-space tag matches. It then returns `lk_pa` = {ppn[21:2], VA[11:0]}, where `wr_ppn` holds PA[31:10].
- R3: A 1 KB entry (`wr_size`=0) also compares VA[11:10] and returns `lk_pa` = {ppn, VA[9:0]}. Another 1 KB sub-page of the same 4 KB region misses.
- R4: A non-global entry misses when `lk_asid` differs from its stored tag. An entry written with `wr_shared`=1 hits under any `lk_asid` and reports `lk_shared`=1.
- R5: The set index is VA[16:12] (written as `wr_vpn[6:2]`) for both page sizes. The four ways of a set hold independent entries. An explicit write (`wr_rand`=0) replaces only way `wr_way`, and `lk_way` names the way that hit.
- R6: With `wr_rand`=1 the victim is a 2-bit counter that is 0 after reset and advances by one every clock. As a result, random writes on four consecutive cycles fill four different ways.
- R7: When more than one way of the indexed set matches, `lk_hit`=1 and `lk_multi`=1, and the data come from the lowest-numbered matching way. When exactly one way matches, `lk_multi`=0.
- R8: Rights encoding: bit 1 grants user access and bit 0 grants writes. `lk_viol`=1 when a hit occurs and either (`lk_user` and not bit 1) or (`lk_write` and not bit 0). `lk_prot` reports the stored field.
- R9: A cycle with `flush`=1 clears every entry at its clock edge. A write presented in the same cycle is discarded.
- R10: A write takes effect at the clock edge that samples it. A lookup in the same cycle still sees the old contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Invalidate every entry |
| wr_en | input | 1 | Write an entry this cycle |
| wr_rand | input | 1 | 1: counter picks the way; 0: use `wr_way` |
| wr_way | input | 2 | Explicit target way |
| wr_vpn | input | 22 | Virtual page bits VA[31:10] of the new entry |
| wr_asid | input | 8 | Address-space tag of the new entry |
| wr_shared | input | 1 | Global entry, ignores the tag |
| wr_size | input | 1 | 1 = 4 KB page, 0 = 1 KB page |
| wr_ppn | input | 22 | Physical page bits PA[31:10] |
| wr_prot | input | 2 | Rights: bit 1 user, bit 0 write |
| lk_va | input | 32 | Lookup virtual address |
| lk_asid | input | 8 | Current address-space tag |
| lk_user | input | 1 | Access is from user mode |
| lk_write | input | 1 | Access is a write |
| lk_hit | output | 1 | Translation found |
| lk_multi | output | 1 | More than one way matched |
| lk_way | output | 2 | Way that supplied the result |
| lk_pa | output | 32 | Translated physical address |
| lk_prot | output | 2 | Rights of the hit entry |
| lk_shared | output | 1 | Hit entry is global |
| lk_viol | output | 1 | Rights check failed |

## Verification
The interesting overlap is an invalidate and a refill presented in the same cycle. The bench drives `flush` and `wr_en` together, with a new page, on a set that already holds an older entry. Within that cycle it confirms that the older entry still hits, because lookup reads the pre-edge contents. After the edge it requires both the older page and the page that was being written to miss.

// File: rtl/asid_tlb_pkg.sv
package asid_tlb_pkg;

    localparam int VA_W   = 32;
    localparam int ASID_W = 8;
    localparam int OFF_W  = 10;
    localparam int VPN_W  = VA_W - OFF_W;
    localparam int PPN_W  = VA_W - OFF_W;
    localparam int PROT_W = 2;

    typedef enum logic {
        PG_1K = 1'b0,
        PG_4K = 1'b1
    } pgsz_e;

    typedef struct packed {
        logic              shared;
        pgsz_e             size;
        logic [ASID_W-1:0] asid;
        logic [VPN_W-1:0]  vpn;
        logic [PPN_W-1:0]  ppn;
        logic [PROT_W-1:0] prot;
    } tlb_ent_t;

    function automatic logic tag_match(tlb_ent_t e, logic [VPN_W-1:0] vpn,
                                       logic [ASID_W-1:0] asid);
        logic hi_eq, lo_eq, as_eq;
        hi_eq = (e.vpn[VPN_W-1:2] == vpn[VPN_W-1:2]);
        lo_eq = (e.size == PG_4K) || (e.vpn[1:0] == vpn[1:0]);
        as_eq = e.shared || (e.asid == asid);
        return hi_eq && lo_eq && as_eq;
    endfunction

    function automatic logic [VA_W-1:0] compose_pa(tlb_ent_t e, logic [VA_W-1:0] va);
        if (e.size == PG_4K)
            return {e.ppn[PPN_W-1:2], va[OFF_W+1:0]};
        return {e.ppn, va[OFF_W-1:0]};
    endfunction

    function automatic logic rights_fail(logic [PROT_W-1:0] prot, logic user, logic wr);
        return (user && !prot[1]) || (wr && !prot[0]);
    endfunction

endpackage

// File: rtl/asid_tlb_victim.sv
module asid_tlb_victim #(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic             clk,
    input  logic             rst,
    output logic [WAY_W-1:0] victim
);
    always_ff @(posedge clk) begin
        if (rst) victim <= '0;
        else     victim <= victim + 1'b1;
    end
endmodule

// File: rtl/asid_tlb_way.sv
module asid_tlb_way
    import asid_tlb_pkg::*;
#(
    parameter int SETS  = 32,
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_go,
    input  logic [IDX_W-1:0]  wr_idx,
    input  tlb_ent_t          wr_ent,
    input  logic [IDX_W-1:0]  rd_idx,
    input  logic [VPN_W-1:0]  rd_vpn,
    input  logic [ASID_W-1:0] rd_asid,
    output logic              match,
    output tlb_ent_t          rd_ent
);
    tlb_ent_t         mem [SETS];
    logic [SETS-1:0]  vld;

    always_ff @(posedge clk) begin
        if (rst || flush)
            vld <= '0;
        else if (wr_go)
            vld[wr_idx] <= 1'b1;
    end

    always_ff @(posedge clk) begin
        if (wr_go && !flush)
            mem[wr_idx] <= wr_ent;
    end

    always_comb begin
        rd_ent = mem[rd_idx];
        match  = vld[rd_idx] && tag_match(rd_ent, rd_vpn, rd_asid);
    end
endmodule

// File: rtl/asid_tlb_select.sv
module asid_tlb_select
    import asid_tlb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]           match,
    input  tlb_ent_t [WAYS-1:0]       ents,
    output logic                      hit,
    output logic                      multi,
    output logic [WAY_W-1:0]          way,
    output tlb_ent_t                  sel
);
    localparam int CNT_W = $clog2(WAYS + 1);
    logic [CNT_W-1:0] cnt;

    always_comb begin
        hit = 1'b0;
        way = '0;
        sel = '0;
        cnt = '0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (match[i]) begin
                hit = 1'b1;
                way = WAY_W'(i);
                sel = ents[i];
                cnt = cnt + 1'b1;
            end
        end
        multi = (cnt > 1);
    end
endmodule

// File: rtl/asid_tlb.sv
module asid_tlb
    import asid_tlb_pkg::*;
#(
    parameter int WAYS  = 4,
    parameter int SETS  = 32,
    parameter int WAY_W = $clog2(WAYS),
    parameter int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              flush,
    input  logic              wr_en,
    input  logic              wr_rand,
    input  logic [WAY_W-1:0]  wr_way,
    input  logic [VPN_W-1:0]  wr_vpn,
    input  logic [ASID_W-1:0] wr_asid,
    input  logic              wr_shared,
    input  logic              wr_size,
    input  logic [PPN_W-1:0]  wr_ppn,
    input  logic [PROT_W-1:0] wr_prot,
    input  logic [VA_W-1:0]   lk_va,
    input  logic [ASID_W-1:0] lk_asid,
    input  logic              lk_user,
    input  logic              lk_write,
    output logic              lk_hit,
    output logic              lk_multi,
    output logic [WAY_W-1:0]  lk_way,
    output logic [VA_W-1:0]   lk_pa,
    output logic [PROT_W-1:0] lk_prot,
    output logic              lk_shared,
    output logic              lk_viol
);
    localparam int IDX_LSB = 2;

    logic [WAY_W-1:0]     victim;
    logic [WAY_W-1:0]     tgt_way;
    logic                 wr_go;
    tlb_ent_t             new_ent;
    logic [IDX_W-1:0]     wr_idx;
    logic [IDX_W-1:0]     rd_idx;
    logic [VPN_W-1:0]     rd_vpn;
    logic [WAYS-1:0]      match;
    tlb_ent_t [WAYS-1:0]  ents;
    tlb_ent_t             sel;
    logic                 any_hit;

    asid_tlb_victim #(.WAYS(WAYS), .WAY_W(WAY_W)) victim_i (
        .clk(clk), .rst(rst), .victim(victim)
    );

    always_comb begin
        tgt_way        = wr_rand ? victim : wr_way;
        wr_go          = wr_en && !flush;
        wr_idx         = wr_vpn[IDX_LSB +: IDX_W];
        rd_vpn         = lk_va[VA_W-1:OFF_W];
        rd_idx         = rd_vpn[IDX_LSB +: IDX_W];
        new_ent.shared = wr_shared;
        new_ent.size   = pgsz_e'(wr_size);
        new_ent.asid   = wr_asid;
        new_ent.vpn    = wr_vpn;
        new_ent.ppn    = wr_ppn;
        new_ent.prot   = wr_prot;
    end

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        asid_tlb_way #(.SETS(SETS), .IDX_W(IDX_W)) way_i (
            .clk     (clk),
            .rst     (rst),
            .flush   (flush),
            .wr_go   (wr_go && (tgt_way == WAY_W'(w))),
            .wr_idx  (wr_idx),
            .wr_ent  (new_ent),
            .rd_idx  (rd_idx),
            .rd_vpn  (rd_vpn),
            .rd_asid (lk_asid),
            .match   (match[w]),
            .rd_ent  (ents[w])
        );
    end

    asid_tlb_select #(.WAYS(WAYS), .WAY_W(WAY_W)) select_i (
        .match (match),
        .ents  (ents),
        .hit   (any_hit),
        .multi (lk_multi),
        .way   (lk_way),
        .sel   (sel)
    );

    always_comb begin
        lk_hit    = any_hit;
        lk_pa     = any_hit ? compose_pa(sel, lk_va) : '0;
        lk_prot   = any_hit ? sel.prot : '0;
        lk_shared = any_hit && sel.shared;
        lk_viol   = any_hit && rights_fail(sel.prot, lk_user, lk_write);
    end
endmodule

// File: rtl/asid_tlb_chk.sv
module asid_tlb_chk (
    input logic        clk,
    input logic        rst,
    input logic        flush,
    input logic        lk_hit,
    input logic        lk_multi,
    input logic        lk_viol,
    input logic [31:0] lk_va,
    input logic [31:0] lk_pa
);
    // R9
    flush_clears_chk: assert property (@(posedge clk) disable iff (rst)
        flush |=> !lk_hit);
    // R7
    multi_implies_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_multi |-> lk_hit);
    // R8
    viol_needs_hit_chk: assert property (@(posedge clk) disable iff (rst)
        lk_viol |-> lk_hit);
    // R1
    miss_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !lk_hit |-> (lk_pa == 32'h0));
    // R3
    offset_pass_chk: assert property (@(posedge clk) disable iff (rst)
        lk_hit |-> (lk_pa[9:0] == lk_va[9:0]));
endmodule

bind asid_tlb asid_tlb_chk chk_i (
    .clk(clk), .rst(rst), .flush(flush), .lk_hit(lk_hit), .lk_multi(lk_multi),
    .lk_viol(lk_viol), .lk_va(lk_va), .lk_pa(lk_pa)
);

// File: tb/asid_tlb_tb_top.sv
`timescale 1ns/1ps
module asid_tlb_tb_top;
    logic        clk = 0;
    logic        rst = 1;
    logic        flush = 0, wr_en = 0, wr_rand = 0, wr_shared = 0, wr_size = 0;
    logic [1:0]  wr_way = 0, wr_prot = 0;
    logic [21:0] wr_vpn = 0, wr_ppn = 0;
    logic [7:0]  wr_asid = 0, lk_asid = 0;
    logic [31:0] lk_va = 0;
    logic        lk_user = 0, lk_write = 0;
    logic        lk_hit, lk_multi, lk_shared, lk_viol;
    logic [1:0]  lk_way, lk_prot;
    logic [31:0] lk_pa;
    int checks = 0, errors = 0;

    always #10 clk = ~clk;

    asid_tlb dut_i (
        .clk(clk), .rst(rst), .flush(flush), .wr_en(wr_en), .wr_rand(wr_rand),
        .wr_way(wr_way), .wr_vpn(wr_vpn), .wr_asid(wr_asid), .wr_shared(wr_shared),
        .wr_size(wr_size), .wr_ppn(wr_ppn), .wr_prot(wr_prot), .lk_va(lk_va),
        .lk_asid(lk_asid), .lk_user(lk_user), .lk_write(lk_write), .lk_hit(lk_hit),
        .lk_multi(lk_multi), .lk_way(lk_way), .lk_pa(lk_pa), .lk_prot(lk_prot),
        .lk_shared(lk_shared), .lk_viol(lk_viol)
    );

    task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic put(logic [31:0] va, logic [7:0] asid, logic sh, logic sz,
                       logic [21:0] ppn, logic [1:0] prot, logic [1:0] way);
        @(negedge clk);
        wr_en = 1; wr_rand = 0; wr_way = way; wr_vpn = va[31:10]; wr_asid = asid;
        wr_shared = sh; wr_size = sz; wr_ppn = ppn; wr_prot = prot;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic look(logic [31:0] va, logic [7:0] asid, logic u, logic w);
        lk_va = va; lk_asid = asid; lk_user = u; lk_write = w;
        #2;
    endtask

    task automatic t_reset;
        look(32'h1234_5ABC, 8'h11, 0, 0);
        chk("R1 hit", lk_hit, 0);
        chk("R1 pa", lk_pa, 0);
    endtask

    task automatic t_page4k;
        logic [21:0] ppn = 22'h12345;
        @(negedge clk);
        wr_en = 1; wr_rand = 0; wr_way = 1; wr_vpn = 22'h048D14; wr_asid = 8'h11;
        wr_shared = 0; wr_size = 1; wr_ppn = ppn; wr_prot = 2'b11;
        look(32'h1234_5ABC, 8'h11, 0, 0);
        chk("R10 old contents in write cycle", lk_hit, 0);
        @(negedge clk);
        wr_en = 0;
        look(32'h1234_5ABC, 8'h11, 0, 0);
        chk("R10 visible after edge", lk_hit, 1);
        chk("R2 pa", lk_pa, {ppn[21:2], 12'hABC});
        chk("R5 way", lk_way, 1);
        chk("R7 single no multi", lk_multi, 0);
    endtask

    task automatic t_page1k;
        logic [21:0] ppn = 22'h3FF00;
        put(32'h0000_7400, 8'h03, 0, 0, ppn, 2'b11, 0);
        look(32'h0000_74F0, 8'h03, 0, 0);
        chk("R3 hit", lk_hit, 1);
        chk("R3 pa", lk_pa, {ppn, 10'h0F0});
        look(32'h0000_7800, 8'h03, 0, 0);
        chk("R3 other subpage", lk_hit, 0);
    endtask

    task automatic t_asid;
        look(32'h1234_5ABC, 8'h22, 0, 0);
        chk("R4 asid mismatch", lk_hit, 0);
        put(32'h0ABC_D000, 8'h40, 1, 1, 22'h00100, 2'b11, 2);
        look(32'h0ABC_D010, 8'h99, 0, 0);
        chk("R4 shared hit", lk_hit, 1);
        chk("R4 shared flag", lk_shared, 1);
    endtask

    task automatic t_ways;
        for (int k = 0; k < 4; k++)
            put(32'h1000_9000 + (k << 28), 8'h07, 0, 1, 22'(k + 8), 2'b11, 2'(k));
        for (int k = 0; k < 4; k++) begin
            look(32'h1000_9000 + (k << 28), 8'h07, 0, 0);
            chk("R5 set member hit", lk_hit, 1);
            chk("R5 set member way", lk_way, k);
        end
        put(32'h5500_9000, 8'h07, 0, 1, 22'h00040, 2'b11, 2);
        look(32'h3000_9000, 8'h07, 0, 0);
        chk("R5 replaced way misses", lk_hit, 0);
        look(32'h4000_9000, 8'h07, 0, 0);
        chk("R5 neighbour way kept", lk_hit, 1);
        look(32'h5500_9000, 8'h07, 0, 0);
        chk("R5 new entry way", lk_way, 2);
    endtask

    task automatic t_flush_vs_write;
        @(negedge clk);
        flush = 1; wr_en = 1; wr_rand = 0; wr_way = 3; wr_vpn = 22'h1A0024;
        wr_asid = 8'h07; wr_shared = 0; wr_size = 1; wr_ppn = 22'h1; wr_prot = 2'b11;
        look(32'h1000_9000, 8'h07, 0, 0);
        chk("R9 pre-edge lookup sees old", lk_hit, 1);
        @(negedge clk);
        flush = 0; wr_en = 0;
        look(32'h1000_9000, 8'h07, 0, 0);
        chk("R9 old entry cleared", lk_hit, 0);
        look(32'h6800_9000, 8'h07, 0, 0);
        chk("R9 simultaneous write dropped", lk_hit, 0);
    endtask

    task automatic t_random;
        logic [3:0] seen = 0;
        @(negedge clk);
        wr_en = 1; wr_rand = 1; wr_way = 0; wr_asid = 8'h09; wr_shared = 0;
        wr_size = 1; wr_ppn = 22'h2; wr_prot = 2'b11;
        for (int k = 0; k < 4; k++) begin
            wr_vpn = 22'((32'h2000_3000 + (k << 24)) >> 10);
            @(negedge clk);
        end
        wr_en = 0; wr_rand = 0;
        for (int k = 0; k < 4; k++) begin
            look(32'h2000_3000 + (k << 24), 8'h09, 0, 0);
            chk("R6 random entry hit", lk_hit, 1);
            seen[lk_way] = 1'b1;
        end
        chk("R6 four distinct ways", seen, 4'hF);
    endtask

    task automatic t_multi;
        put(32'h3000_4000, 8'h05, 0, 1, 22'h0AAAA, 2'b11, 3);
        put(32'h3000_4000, 8'h05, 0, 1, 22'h15554, 2'b11, 1);
        look(32'h3000_4123, 8'h05, 0, 0);
        chk("R7 hit", lk_hit, 1);
        chk("R7 multi", lk_multi, 1);
        chk("R7 lowest way", lk_way, 1);
        chk("R7 lowest way data", lk_pa, {20'h05555, 12'h123});
    endtask

    task automatic t_prot;
        put(32'h7000_8000, 8'h01, 0, 1, 22'h4, 2'b00, 0);
        look(32'h7000_8000, 8'h01, 1, 0);
        chk("R8 user on priv page", lk_viol, 1);
        chk("R8 prot field", lk_prot, 0);
        look(32'h7000_8000, 8'h01, 0, 1);
        chk("R8 write on read-only", lk_viol, 1);
        look(32'h7000_8000, 8'h01, 0, 0);
        chk("R8 priv read ok", lk_viol, 0);
        put(32'h7100_8000, 8'h01, 0, 1, 22'h4, 2'b11, 1);
        look(32'h7100_8000, 8'h01, 1, 1);
        chk("R8 user write allowed", lk_viol, 0);
        chk("R8 prot field rw", lk_prot, 3);
    endtask

    initial begin
        #(20 * 100000);
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        t_reset;
        t_page4k;
        t_page1k;
        t_asid;
        t_ways;
        t_flush_vs_write;
        t_random;
        t_multi;
        t_prot;
        @(negedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule